// File: doc/BRIEF.md
# Key-Locked System Control Register Bank

This block is a bank of 32-bit control and status words behind a word-addressed synchronous register bus. Software must write a 16-bit unlock key to a dedicated register before most registers will take a write. A second key closes the bank again. Each word offset has an access class: read-write, read-only, write-only or unmapped. Illegal writes are discarded. Any illegal access raises a one-clock error flag in the next cycle.

One reset-control word carries a soft-reset bit. Setting that bit while the bank is unlocked stores the data and produces a one-clock system reset request. An outside reset controller acts on that request. The bank's own contents are not changed by it.

The bus is a register port and not a stream. It has no valid/ready pair and no back-pressure. An access is accepted in every cycle in which `wr_en` or `rd_en` is high. Read data appears one cycle later and holds until the next read. The clock, PLL and pin-mux functions that the stored values would drive are outside this block.

Top module: `sysctl_keybank`

## Requirements
- R1: After reset the bank is locked and the lock-status word (byte 0x00C) reads 1. The following reset values apply. Bytes 0x100–0x108 hold 0x0001A008. Byte 0x10C holds 0x0000003F. Bytes 0x110–0x118 hold 0x00014000. Bytes 0x17C, 0x18C, 0x19C and 0x1AC hold 0x00010000. Byte 0x254 holds 0x00000040. Byte 0x25C holds the boot parameter (default 1). Byte 0x530 holds the ID parameter (default 0x0A5C1001). Bytes 0x700–0x7D4 hold 0x00001601, except bytes 0x708–0x720, which hold 0x00000601. Every other word holds 0. The error flag, the reset request and rdata are all low.
- R2: A write to byte 0x004 whose low 16 bits are 0x767B sets the lock. A write to byte 0x008 whose low 16 bits are 0xDF0D clears the lock. The upper 16 bits are ignored. Any other value written to either register leaves the lock state unchanged.
- R3: While the bank is locked, a write to any writable word other than 0x000, 0x004 and 0x008 is discarded and raises the error flag.
- R4: The word at byte 0x000 accepts writes while the bank is locked, without an error. It keeps only bit 0 of wdata and reads 0 in bits 31:1.
- R5: A write to a read-only or unmapped word is discarded and raises the error flag, whether the bank is locked or unlocked.
- R6: A read of a write-only word returns the stored value and raises the error flag. The stored value of 0x004 and 0x008 is always 0. A read of an unmapped word returns 0 and raises the error flag.
- R7: The access map is as follows.
  - Read-write: 0x000, 0x100–0x108, 0x110–0x118, 0x120–0x1AC (excluding the four words in R1 at 0x17C, 0x18C, 0x19C and 0x1AC), 0x200–0x238, 0x240, 0x244, 0x24C, 0x254, 0x258, 0x600, 0x61C and 0x700–0x7D4.
  - Write-only: 0x004, 0x008, 0x60C and 0x614.
  - Read-only: 0x00C, 0x10C, those four words, 0x25C, 0x530, 0x618 and 0x620.
  - Every other offset is unmapped.

  While unlocked, a legal write stores all 32 bits. A legal read returns the word in the cycle after `rd_en`, with no error.
- R8: A write to byte 0x200 while unlocked with wdata bit 0 set stores the data. It also raises `sys_rst_req` for exactly one cycle, the cycle after the write. With bit 0 clear, or while locked, no request is raised. The request changes no register content.
- R9: Writes to 0x004 and 0x008 never raise the error flag, whatever the key value.
- R10: The error flag is high only in the cycle after an offending access and is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW (10) | Word address, byte offset bits 11:2 |
| wr_en | input | 1 | Write strobe for this cycle |
| rd_en | input | 1 | Read strobe for this cycle |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Registered read data, valid the cycle after rd_en |
| err_pulse | output | 1 | One-cycle illegal-access flag |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
Several properties are checked on every cycle by the bound assertions. The lock changes only through key writes. A correct key always reaches the stated lock state. Locked writes to guarded words are always flagged. Key-register writes are never flagged. Unmapped reads always return zero with a flag. The scratch word never shows upper bits. Every reset request traces back to an unlocked soft-reset write. Other matters can only be shown by the bench's sweeps over all 1024 offsets, in both lock states. These are the exact reset value of each word, the class of each offset, that discarded writes really leave contents untouched, and that a reset request leaves every stored word alone.

// File: rtl/sckb_pkg.sv
package sckb_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RW   = 2'd1,
    ACC_RO   = 2'd2,
    ACC_WO   = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    ROLE_PLAIN   = 3'd0,
    ROLE_SCRATCH = 3'd1,
    ROLE_LOCK    = 3'd2,
    ROLE_UNLOCK  = 3'd3,
    ROLE_STATUS  = 3'd4,
    ROLE_SOFTRST = 3'd5
  } role_e;

  localparam int unsigned BOFS_SCRATCH = 'h000;
  localparam int unsigned BOFS_LOCK    = 'h004;
  localparam int unsigned BOFS_UNLOCK  = 'h008;
  localparam int unsigned BOFS_STATUS  = 'h00C;
  localparam int unsigned BOFS_SOFTRST = 'h200;
  localparam int unsigned SPACE_BYTES  = 'h1000;

  // Access class of a word index (byte offset = 4 * index).
  function automatic acc_e word_access(input int unsigned w);
    int unsigned b;
    b = w * 4;
    if (b >= SPACE_BYTES) return ACC_NONE;
    if (b == BOFS_LOCK || b == BOFS_UNLOCK || b == 'h60C || b == 'h614)
      return ACC_WO;
    if (b == BOFS_STATUS || b == 'h10C || b == 'h25C || b == 'h530 ||
        b == 'h618 || b == 'h620)
      return ACC_RO;
    if (b >= 'h170 && b <= 'h1AC)
      return ((b & 'hF) == 'hC) ? ACC_RO : ACC_RW;
    if (b == BOFS_SCRATCH ||
        (b >= 'h100 && b <= 'h108) || (b >= 'h110 && b <= 'h118) ||
        (b >= 'h120 && b <= 'h16C) || (b >= 'h200 && b <= 'h238) ||
        b == 'h240 || b == 'h244 || b == 'h24C || b == 'h254 ||
        b == 'h258 || b == 'h600 || b == 'h61C ||
        (b >= 'h700 && b <= 'h7D4))
      return ACC_RW;
    return ACC_NONE;
  endfunction

  // Special behaviour attached to a word index.
  function automatic role_e word_role(input int unsigned w);
    int unsigned b;
    b = w * 4;
    if (b == BOFS_SCRATCH) return ROLE_SCRATCH;
    if (b == BOFS_LOCK)    return ROLE_LOCK;
    if (b == BOFS_UNLOCK)  return ROLE_UNLOCK;
    if (b == BOFS_STATUS)  return ROLE_STATUS;
    if (b == BOFS_SOFTRST) return ROLE_SOFTRST;
    return ROLE_PLAIN;
  endfunction

  // Value a word takes at reset.
  function automatic logic [31:0] word_reset(input int unsigned w,
                                             input logic [31:0] boot_val,
                                             input logic [31:0] id_val);
    int unsigned b;
    int unsigned pin;
    b = w * 4;
    if (b >= 'h100 && b <= 'h108) return 32'h0001_A008;
    if (b == 'h10C)               return 32'h0000_003F;
    if (b >= 'h110 && b <= 'h118) return 32'h0001_4000;
    if (b >= 'h170 && b <= 'h1AC && (b & 'hF) == 'hC) return 32'h0001_0000;
    if (b == 'h254)               return 32'h0000_0040;
    if (b == 'h25C)               return boot_val;
    if (b == 'h530)               return id_val;
    if (b >= 'h700 && b <= 'h7D4) begin
      pin = (b - 'h700) / 4;
      return (pin >= 2 && pin <= 8) ? 32'h0000_0601 : 32'h0000_1601;
    end
    return 32'h0;
  endfunction

endpackage

// File: rtl/sckb_offset_map.sv
module sckb_offset_map
  import sckb_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic [AW-1:0] idx,
  output acc_e          acc,
  output role_e         role
);

  always_comb begin
    acc  = word_access(32'(idx));
    role = word_role(32'(idx));
  end

endmodule

// File: rtl/sckb_gate.sv
module sckb_gate
  import sckb_pkg::*;
#(
  parameter int unsigned       KEY_W      = 16,
  parameter logic [KEY_W-1:0]  LOCK_KEY   = 16'h767B,
  parameter logic [KEY_W-1:0]  UNLOCK_KEY = 16'hDF0D
) (
  input  logic             wr_en,
  input  logic             rd_en,
  input  acc_e             acc,
  input  role_e            role,
  input  logic [KEY_W-1:0] key_bits,
  input  logic             go_bit,
  input  logic             locked,
  output logic             store_we,
  output logic             lock_set,
  output logic             lock_clr,
  output logic             soft_hit,
  output logic             err_now
);

  logic key_reg;
  logic lock_free;
  logic writable;
  logic wr_bad;
  logic rd_bad;

  always_comb begin
    key_reg   = (role == ROLE_LOCK) || (role == ROLE_UNLOCK);
    lock_free = key_reg || (role == ROLE_SCRATCH);
    writable  = (acc == ACC_RW) || (acc == ACC_WO);

    wr_bad   = wr_en && (!writable || (locked && !lock_free));
    rd_bad   = rd_en && ((acc == ACC_NONE) || (acc == ACC_WO));

    store_we = wr_en && writable && !key_reg && (!locked || lock_free);
    lock_set = wr_en && (role == ROLE_LOCK)   && (key_bits == LOCK_KEY);
    lock_clr = wr_en && (role == ROLE_UNLOCK) && (key_bits == UNLOCK_KEY);
    soft_hit = store_we && (role == ROLE_SOFTRST) && go_bit;
    err_now  = wr_bad || rd_bad;
  end

endmodule

// File: rtl/sckb_lock_fsm.sv
module sckb_lock_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_set,
  input  logic lock_clr,
  output logic locked
);

  typedef enum logic {ST_CLOSED = 1'b1, ST_OPEN = 1'b0} lock_st_e;
  lock_st_e st_q;
  lock_st_e st_d;

  always_comb begin
    st_d = st_q;
    if (lock_set)      st_d = ST_CLOSED;
    else if (lock_clr) st_d = ST_OPEN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_CLOSED;
    else        st_q <= st_d;
  end

  assign locked = (st_q == ST_CLOSED);

endmodule

// File: rtl/sckb_store.sv
module sckb_store
  import sckb_pkg::*;
#(
  parameter int unsigned AW       = 10,
  parameter int unsigned DW       = 32,
  parameter logic [31:0] BOOT_VAL = 32'h0000_0001,
  parameter logic [31:0] ID_VAL   = 32'h0A5C_1001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_word
);

  localparam int unsigned WORDS = 1 << AW;

  logic [WORDS-1:0][DW-1:0] words;

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    localparam acc_e        A_I  = word_access(i);
    localparam role_e       R_I  = word_role(i);
    localparam logic [31:0] RV_I = word_reset(i, BOOT_VAL, ID_VAL);

    if ((A_I == ACC_RW || A_I == ACC_WO) &&
        R_I != ROLE_LOCK && R_I != ROLE_UNLOCK) begin : g_held
      if (R_I == ROLE_SCRATCH) begin : g_bit
        logic q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)                      q <= RV_I[0];
          else if (we && wr_idx == AW'(i)) q <= wdata[0];
        end
        assign words[i] = {{(DW-1){1'b0}}, q};
      end else begin : g_full
        logic [DW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)                      q <= DW'(RV_I);
          else if (we && wr_idx == AW'(i)) q <= wdata;
        end
        assign words[i] = q;
      end
    end else begin : g_fixed
      assign words[i] = DW'(RV_I);
    end
  end

  assign rd_word = words[rd_idx];

endmodule

// File: rtl/sysctl_keybank.sv
module sysctl_keybank
  import sckb_pkg::*;
#(
  parameter int unsigned      AW         = 10,
  parameter int unsigned      DW         = 32,
  parameter int unsigned      KEY_W      = 16,
  parameter logic [KEY_W-1:0] LOCK_KEY   = 16'h767B,
  parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'hDF0D,
  parameter logic [31:0]      BOOT_VAL   = 32'h0000_0001,
  parameter logic [31:0]      ID_VAL     = 32'h0A5C_1001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          err_pulse,
  output logic          sys_rst_req
);

  acc_e          acc;
  role_e         role;
  logic          locked;
  logic          store_we;
  logic          lock_set;
  logic          lock_clr;
  logic          soft_hit;
  logic          err_now;
  logic [DW-1:0] word;
  logic [DW-1:0] rd_next;

  sckb_offset_map #(.AW(AW)) u_map (
    .idx  (addr),
    .acc  (acc),
    .role (role)
  );

  sckb_gate #(
    .KEY_W      (KEY_W),
    .LOCK_KEY   (LOCK_KEY),
    .UNLOCK_KEY (UNLOCK_KEY)
  ) u_gate (
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .acc      (acc),
    .role     (role),
    .key_bits (wdata[KEY_W-1:0]),
    .go_bit   (wdata[0]),
    .locked   (locked),
    .store_we (store_we),
    .lock_set (lock_set),
    .lock_clr (lock_clr),
    .soft_hit (soft_hit),
    .err_now  (err_now)
  );

  sckb_lock_fsm u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock_set (lock_set),
    .lock_clr (lock_clr),
    .locked   (locked)
  );

  sckb_store #(
    .AW       (AW),
    .DW       (DW),
    .BOOT_VAL (BOOT_VAL),
    .ID_VAL   (ID_VAL)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (store_we),
    .wr_idx  (addr),
    .wdata   (wdata),
    .rd_idx  (addr),
    .rd_word (word)
  );

  always_comb begin
    if (role == ROLE_STATUS) rd_next = {{(DW-1){1'b0}}, locked};
    else                     rd_next = word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata       <= '0;
      err_pulse   <= 1'b0;
      sys_rst_req <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_next;
      err_pulse   <= err_now;
      sys_rst_req <= soft_hit;
    end
  end

endmodule

// File: rtl/sckb_checker.sv
module sckb_checker
  import sckb_pkg::*;
#(
  parameter int unsigned      AW         = 10,
  parameter int unsigned      DW         = 32,
  parameter int unsigned      KEY_W      = 16,
  parameter logic [KEY_W-1:0] LOCK_KEY   = 16'h767B,
  parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'hDF0D
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    addr,
  input logic             wr_en,
  input logic             rd_en,
  input logic [KEY_W-1:0] key_bits,
  input logic             go_bit,
  input logic [DW-1:0]    rdata,
  input logic             err_pulse,
  input logic             sys_rst_req,
  input logic             locked
);

  localparam logic [AW-1:0] W_SCR  = AW'(BOFS_SCRATCH / 4);
  localparam logic [AW-1:0] W_LCK  = AW'(BOFS_LOCK / 4);
  localparam logic [AW-1:0] W_ULK  = AW'(BOFS_UNLOCK / 4);
  localparam logic [AW-1:0] W_SRST = AW'(BOFS_SOFTRST / 4);

  logic at_key;
  logic guarded_wr;
  logic unmapped_rd;
  logic srst_go;

  assign at_key      = (addr == W_LCK) || (addr == W_ULK);
  assign guarded_wr  = wr_en && (word_access(32'(addr)) == ACC_RW) &&
                       (addr != W_SCR);
  assign unmapped_rd = rd_en && (word_access(32'(addr)) == ACC_NONE);
  assign srst_go     = wr_en && (addr == W_SRST) && go_bit && !locked;

  a_r2_lock_key: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == W_LCK && key_bits == LOCK_KEY) |=> locked);

  a_r2_unlock_key: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == W_ULK && key_bits == UNLOCK_KEY) |=> !locked);

  a_r2_lock_moves_on_key_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(locked) |-> $past(wr_en && at_key));

  a_r3_locked_write_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && guarded_wr) |=> err_pulse);

  a_r4_scratch_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == W_SCR) |=> (rdata[DW-1:1] == '0));

  a_r6_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_rd |=> (rdata == '0 && err_pulse));

  a_r8_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(srst_go));

  a_r9_key_write_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && at_key) |=> !err_pulse);

  a_r10_err_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(wr_en || rd_en));

endmodule

bind sysctl_keybank sckb_checker #(
  .AW         (AW),
  .DW         (DW),
  .KEY_W      (KEY_W),
  .LOCK_KEY   (LOCK_KEY),
  .UNLOCK_KEY (UNLOCK_KEY)
) u_sckb_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr        (addr),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .key_bits    (wdata[KEY_W-1:0]),
  .go_bit      (wdata[0]),
  .rdata       (rdata),
  .err_pulse   (err_pulse),
  .sys_rst_req (sys_rst_req),
  .locked      (locked)
);

// File: tb/sysctl_keybank_bench.sv
`timescale 1ns/1ps
module sysctl_keybank_bench;

  localparam int AW    = 10;
  localparam int DW    = 32;
  localparam int WORDS = 1 << AW;
  localparam logic [31:0] BOOT = 32'h0000_0001;
  localparam logic [31:0] IDV  = 32'h0A5C_1001;
  localparam int W_SRST = 'h200 / 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          err_pulse;
  logic          sys_rst_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [31:0] mdl [WORDS];
  bit          mdl_locked;

  always #2.5 clk = ~clk;

  sysctl_keybank u_sysctl_keybank (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .wdata       (wdata),
    .rdata       (rdata),
    .err_pulse   (err_pulse),
    .sys_rst_req (sys_rst_req)
  );

  // Class per R7: 0 unmapped, 1 read-write, 2 read-only, 3 write-only.
  function automatic int cls(int w);
    int b;
    b = w * 4;
    case (b) inside
      'h004, 'h008, 'h60C, 'h614: return 3;
      'h00C, 'h10C, 'h17C, 'h18C, 'h19C, 'h1AC,
      'h25C, 'h530, 'h618, 'h620: return 2;
      'h000, ['h100:'h108], ['h110:'h118], ['h120:'h1AC], ['h200:'h238],
      'h240, 'h244, 'h24C, 'h254, 'h258, 'h600, 'h61C,
      ['h700:'h7D4]: return 1;
      default: return 0;
    endcase
  endfunction

  // Reset values per R1.
  function automatic logic [31:0] rstv(int w);
    int b;
    b = w * 4;
    case (b) inside
      ['h100:'h108]: return 32'h0001_A008;
      'h10C:         return 32'h0000_003F;
      ['h110:'h118]: return 32'h0001_4000;
      'h17C, 'h18C, 'h19C, 'h1AC: return 32'h0001_0000;
      'h254:         return 32'h0000_0040;
      'h25C:         return BOOT;
      'h530:         return IDV;
      ['h708:'h720]: return 32'h0000_0601;
      ['h700:'h7D4]: return 32'h0000_1601;
      default:       return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] pat(int w);
    return {6'h2B, w[9:0], 16'h1234 ^ w[15:0]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Write with model update, checking err_pulse and sys_rst_req next cycle.
  task automatic wr_chk(string tag, int w, logic [31:0] d);
    int  c;
    bit  was_locked, free, ok, e_err, e_req;
    c          = cls(w);
    was_locked = mdl_locked;
    free       = (w == 0) || (w == 1) || (w == 2);
    ok         = (c == 1 || c == 3) && (!was_locked || free);
    e_err      = !(c == 1 || c == 3) || ((c == 1 || c == 3) && was_locked && !free);
    e_req      = ok && (w == W_SRST) && d[0];
    if (ok && w != 1 && w != 2) mdl[w] = (w == 0) ? {31'b0, d[0]} : d;
    if (w == 1 && d[15:0] == 16'h767B) mdl_locked = 1'b1;
    if (w == 2 && d[15:0] == 16'hDF0D) mdl_locked = 1'b0;
    @(negedge clk);
    addr  = AW'(w);
    wdata = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk({tag, " err"}, {31'b0, err_pulse}, {31'b0, e_err});
    chk({tag, " req"}, {31'b0, sys_rst_req}, {31'b0, e_req});
  endtask

  task automatic rd_chk(string tag, int w);
    int c;
    logic [31:0] e;
    c = cls(w);
    if (w == 3)      e = {31'b0, mdl_locked};
    else if (c == 0) e = 32'h0;
    else             e = mdl[w];
    @(negedge clk);
    addr  = AW'(w);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk({tag, " data"}, rdata, e);
    chk({tag, " err"}, {31'b0, err_pulse}, {31'b0, (c == 0 || c == 3)});
  endtask

  task automatic sweep_read(string tag);
    for (int w = 0; w < WORDS; w++) rd_chk(tag, w);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int w = 0; w < WORDS; w++) mdl[w] = rstv(w);
    mdl_locked = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset rdata", rdata, 32'h0);
    chk("R1 reset err", {31'b0, err_pulse}, 32'h0);
    chk("R1 reset req", {31'b0, sys_rst_req}, 32'h0);

    // R1 R6 R7: every word's reset value and read class while locked.
    sweep_read("R1 R6 locked reset sweep");

    // R3 R4 R5 R9: locked write sweep; only scratch may change.
    for (int w = 0; w < WORDS; w++) wr_chk("R3 R5 R9 locked write", w, pat(w));
    sweep_read("R3 R4 contents after locked writes");

    // R2: key handling.
    wr_chk("R2 R9 wrong unlock key", 2, 32'h0000_DF0E);
    rd_chk("R2 still locked", 3);
    wr_chk("R2 unlock upper bits ignored", 2, 32'hFFFF_DF0D);
    rd_chk("R2 unlocked", 3);

    // R5 R7: unlocked write sweep, full readback.
    for (int w = 0; w < WORDS; w++) wr_chk("R5 R7 unlocked write", w, pat(w));
    sweep_read("R6 R7 unlocked readback");

    // R8: soft reset request.
    wr_chk("R8 soft reset", W_SRST, 32'h0000_0001);
    @(negedge clk);
    chk("R8 request lasts one cycle", {31'b0, sys_rst_req}, 32'h0);
    chk("R10 err low after legal write", {31'b0, err_pulse}, 32'h0);
    rd_chk("R8 data stored", W_SRST);
    rd_chk("R8 contents untouched", 'h100 / 4);
    rd_chk("R8 pin word untouched", 'h700 / 4);
    wr_chk("R8 bit0 clear no request", W_SRST, 32'h0000_0002);

    // R4: scratch keeps bit 0 only.
    wr_chk("R4 scratch all ones", 0, 32'hFFFF_FFFF);
    rd_chk("R4 scratch readback", 0);

    // R2: relock paths.
    wr_chk("R2 R9 wrong lock key", 1, 32'h0000_767A);
    rd_chk("R2 still unlocked", 3);
    wr_chk("R2 lock", 1, 32'hABCD_767B);
    rd_chk("R2 locked again", 3);
    rd_chk("R6 lock register reads zero", 1);
    wr_chk("R4 scratch write while locked", 0, 32'h0);
    rd_chk("R4 scratch cleared", 0);

    // R3 R8 R10: locked soft-reset write.
    wr_chk("R3 R8 soft reset while locked", W_SRST, 32'h0000_0001);
    @(negedge clk);
    chk("R10 err one cycle only", {31'b0, err_pulse}, 32'h0);
    rd_chk("R3 soft reset word kept", W_SRST);

    finish_run();
  end

endmodule